// File: doc/BRIEF.md
# Shared-Datapath Adder/Subtractor with Carry and Overflow Flags

This block is a purely combinational arithmetic unit that either adds or subtracts two operands of the same width, eight bits by default. Both operations go through one ripple chain of full-adder cells. Subtraction is done by inverting every bit of the second operand and injecting a one as the carry into the lowest stage, which forms the two's-complement negation inside the adder itself.

The unit reports the raw carry out of the top stage and a signed overflow flag. The same result word can therefore be read as unsigned arithmetic, by looking at the carry, or as signed arithmetic, by looking at the overflow flag. The carry is never turned into a borrow: after a subtraction, a carry of one means no borrow occurred. The block has no clock and no reset, and its outputs depend only on the present inputs.

Top module: `adsub_unit`

## Requirements
- R1: With `sub_en`=0, `result` equals (`op_a` + `op_b`) mod 2^W and `carry_out` equals bit W of the (W+1)-bit unsigned sum.
- R2: With `sub_en`=1, `result` equals (`op_a` − `op_b`) mod 2^W.
- R3: With `sub_en`=1, `carry_out` equals bit W of `op_a` + (bitwise NOT `op_b`) + 1. It is 1 exactly when `op_a` ≥ `op_b` as unsigned values, so any operand minus zero gives a carry of 1.
- R4: With `sub_en`=0, `overflow` is 1 exactly when the two's-complement sum of `op_a` and `op_b` lies outside [−2^(W−1), 2^(W−1)−1].
- R5: With `sub_en`=1, `overflow` is 1 exactly when the two's-complement difference `op_a` − `op_b` lies outside that same range.
- R6: 0x00 − 0x03 gives `result`=0xFD, `carry_out`=0 and `overflow`=0.
- R7: 0x7F + 0x41 gives `result`=0xC0, `overflow`=1 and `carry_out`=0.
- R8: 0xBF + 0x81 gives `result`=0x40 with `carry_out`=1. 0x3F + 0x01 gives `result`=0x40 with `carry_out`=0 and `overflow`=0.
- R9: The sign-boundary cases hold:
  - 0x80 − 0x01 gives 0x7F with `carry_out`=1 and `overflow`=1.
  - 0x7F − 0xFF gives 0x80 with `carry_out`=0 and `overflow`=1.
  - 0x80 + 0x80 gives 0x00 with `carry_out`=1 and `overflow`=1.
  - 0x80 − 0x80 gives 0x00 with `carry_out`=1 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand (minuend when subtracting) |
| op_b | input | W | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | W | Sum or difference, modulo 2^W |
| carry_out | output | 1 | Raw carry out of the most significant stage |
| overflow | output | 1 | Two's-complement overflow of the result |

## Verification
The carry flag and the overflow flag are produced by separate logic, and both can assert on the same input vector. This happens, for example, when 0x80 is added to 0x80, or when 0x01 is subtracted from 0x80. The bench drives these coincident cases directly. It then sweeps every operand pair in both modes, so that every mix of the two flags occurs. In every sweep step, all three outputs are judged against a reference built from plain integer arithmetic.

// File: rtl/adsub_pkg.sv
package adsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } adsub_op_e;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    function automatic fa_out_t fa_eval(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/adsub_fa_cell.sv
module adsub_fa_cell
    import adsub_pkg::*;
(
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    fa_out_t res;

    always_comb begin
        res   = fa_eval(x_in, y_in, c_in);
        s_out = res.sum;
        c_out = res.carry;
    end
endmodule

// File: rtl/adsub_operand_cond.sv
module adsub_operand_cond
    import adsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] raw_b,
    input  adsub_op_e    op,
    output logic [W-1:0] eff_b
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_inv
            assign eff_b[i] = raw_b[i] ^ (op == OP_SUB);
        end
    endgenerate
endmodule

// File: rtl/adsub_ripple.sv
module adsub_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = cin;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_stage
            adsub_fa_cell u_fa (
                .x_in  (x[i]),
                .y_in  (y[i]),
                .c_in  (chain[i]),
                .s_out (sum[i]),
                .c_out (chain[i+1])
            );
        end
    endgenerate

    assign cout = chain[W];
endmodule

// File: rtl/adsub_ovf_detect.sv
module adsub_ovf_detect (
    input  logic a_sign,
    input  logic b_eff_sign,
    input  logic s_sign,
    output logic ovf
);
    logic same_in;

    always_comb begin
        same_in = ~(a_sign ^ b_eff_sign);
        ovf     = same_in & (s_sign ^ a_sign);
    end
endmodule

// File: rtl/adsub_unit.sv
module adsub_unit
    import adsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_en,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow
);
    localparam int MSB = W - 1;

    adsub_op_e    op;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum_w;

    assign op = adsub_op_e'(sub_en);

    adsub_operand_cond #(.W(W)) u_cond (
        .raw_b (op_b),
        .op    (op),
        .eff_b (b_eff)
    );

    adsub_ripple #(.W(W)) u_chain (
        .x    (op_a),
        .y    (b_eff),
        .cin  (op == OP_SUB),
        .sum  (sum_w),
        .cout (carry_out)
    );

    adsub_ovf_detect u_ovf (
        .a_sign     (op_a[MSB]),
        .b_eff_sign (b_eff[MSB]),
        .s_sign     (sum_w[MSB]),
        .ovf        (overflow)
    );

    assign result = sum_w;
endmodule

// File: rtl/adsub_unit_chk.sv
module adsub_unit_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         sub_en,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         overflow
);
    logic [W:0]          ref_add;
    logic [W:0]          ref_sub;
    logic signed [W+1:0] sa;
    logic signed [W+1:0] sb;
    logic signed [W+1:0] wide;
    logic signed [W+1:0] sres;

    always_comb begin
        ref_add = {1'b0, op_a} + {1'b0, op_b};
        ref_sub = {1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, 1'b1};
        sa      = {{2{op_a[W-1]}}, op_a};
        sb      = {{2{op_b[W-1]}}, op_b};
        sres    = {{2{result[W-1]}}, result};
        wide    = sub_en ? (sa - sb) : (sa + sb);

        // R1: addition result and carry
        assert_add_sum_R1: assert (sub_en || ({carry_out, result} == ref_add))
            else $error("add mismatch");
        // R2: subtraction result
        assert_sub_diff_R2: assert (!sub_en || (result == ref_sub[W-1:0]))
            else $error("sub result mismatch");
        // R3: raw carry kept on subtraction
        assert_sub_carry_R3: assert (!sub_en || (carry_out == (op_a >= op_b)))
            else $error("sub carry mismatch");
        // R4: signed overflow on add
        assert_add_ovf_R4: assert (sub_en || (overflow == (wide != sres)))
            else $error("add ovf mismatch");
        // R5: signed overflow on subtract
        assert_sub_ovf_R5: assert (!sub_en || (overflow == (wide != sres)))
            else $error("sub ovf mismatch");
    end
endmodule

bind adsub_unit adsub_unit_chk #(.W(W)) u_chk (.*);

// File: tb/adsub_unit_tb.sv
module adsub_unit_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_en = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    adsub_unit #(.W(W)) u_dut (
        .op_a(op_a), .op_b(op_b), .sub_en(sub_en),
        .result(result), .carry_out(carry_out), .overflow(overflow)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (a=%0h b=%0h sub=%0b)",
                     tag, what, act, exp, op_a, op_b, sub_en);
        end
    endtask

    // Reference model: integer arithmetic only.
    task automatic apply_and_check(input int a, input int b, input bit s, input string tag);
        int full, ers, ec, eo, sa, sb, sr;
        @(posedge clk);
        op_a = a[W-1:0]; op_b = b[W-1:0]; sub_en = s;
        @(negedge clk);
        if (s) full = a + ((~b) & 255) + 1;
        else   full = a + b;
        ers = full & 255;
        ec  = (full >> 8) & 1;
        sa  = (a >= 128) ? a - 256 : a;
        sb  = (b >= 128) ? b - 256 : b;
        sr  = s ? sa - sb : sa + sb;
        eo  = (sr < -128 || sr > 127) ? 1 : 0;
        if (tag.len() != 0) begin
            check(tag, "result", int'(result), ers);
            check(tag, "carry", int'(carry_out), ec);
            check(tag, "overflow", int'(overflow), eo);
        end else begin
            check(s ? "R2" : "R1", "result", int'(result), ers);
            check(s ? "R3" : "R1", "carry", int'(carry_out), ec);
            check(s ? "R5" : "R4", "overflow", int'(overflow), eo);
        end
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        // idle state with zero inputs (R1)
        @(negedge clk);
        check("R1", "idle result", int'(result), 0);
        check("R1", "idle carry", int'(carry_out), 0);
        check("R4", "idle overflow", int'(overflow), 0);

        apply_and_check(8'h00, 8'h03, 1, "R6");
        apply_and_check(8'h7F, 8'h41, 0, "R7");
        apply_and_check(8'hBF, 8'h81, 0, "R8");
        apply_and_check(8'h3F, 8'h01, 0, "R8");
        apply_and_check(8'h80, 8'h01, 1, "R9");
        apply_and_check(8'h7F, 8'hFF, 1, "R9");
        apply_and_check(8'h80, 8'h80, 0, "R9");
        apply_and_check(8'h80, 8'h80, 1, "R9");
        apply_and_check(8'h5A, 8'h00, 1, "R3");
        apply_and_check(8'h7F, 8'h7F, 0, "R4");
        apply_and_check(8'h7F, 8'h80, 1, "R5");

        // exhaustive sweep, both modes: R1 R2 R3 R4 R5
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    apply_and_check(a, b, s[0], "");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule